// File: doc/BRIEF.md
# Per-Thread Squash Request Controller

This block sits between the execute stage, the trap logic and the reorder buffer of a multithreaded out-of-order core. Each cycle it decides, separately for every hardware thread, whether a squash is sent to the reorder buffer and which boundary sequence number goes with it. Every instruction younger than the boundary is discarded. The same command doubles as the broadcast record for the earlier pipeline stages: a valid flag, the boundary, the restart PC and a mispredict flag.

Three sources can request a squash:

- **Trap squash.** A trap raised for a thread parks that thread in a waiting state. The squash fires a fixed number of cycles later.
- **Context-change squash.** This trigger acts in the cycle it is asserted.
- **Execute-stage squash.** This request carries its own sequence number, an include-self flag, a restart PC and a mispredict flag. It is accepted only when it is not younger than the youngest instruction the thread has inserted so far, so a younger squash cannot override an older one.

After any squash, a thread stays in its squashing state until the reorder buffer reports that it has finished. While every thread is squashing, insertion is blocked.

Each thread runs a three-state machine:

- **RUN**, code 0.
- **SQUASH**, code 1.
- **TRAPWAIT**, code 2.

Its transitions are:

- **RUN→SQUASH** on any squash.
- **RUN→TRAPWAIT** on a trap raise.
- **TRAPWAIT→SQUASH** when the delayed trap fires.
- **SQUASH→SQUASH** on a fresh squash.
- **SQUASH→RUN** on the reorder buffer's done flag.

Top module: `squash_ctl`

## Requirements
- R1: After reset every thread is in RUN (code 0), its youngest sequence number is 0, its trap countdown is idle, `sq_valid`, `ev_squash` and `ev_mispred` are 0, and `sq_count` is 0.
- R2: An execute squash for thread t is accepted in the same cycle only if `ex_valid[t]` is 1, the thread is not in TRAPWAIT, no trap or context squash fires for t in that cycle, and `ex_seq` is less than or equal to the thread's youngest sequence number. A rejected request produces no squash.
- R3: For an accepted execute squash, the boundary is `ex_seq` minus 1 (modulo 2^SW) when `ex_incl` is 1, and `ex_seq` otherwise. In that case `sq_pc` equals `ex_pc` and `sq_mispred` equals `ex_mispred`.
- R4: The youngest sequence number becomes the boundary after any squash. When there is no squash and insertion is not blocked, it becomes `ins_seq` whenever `ins_valid` is 1.
- R5: `trap_raise` in a cycle where the thread is in RUN and not squashing moves it to TRAPWAIT. The trap squash then fires exactly 6 cycles (TRAP_DELAY) after the raise cycle. `trap_raise` in any other state has no effect.
- R6: A trap or context squash has a boundary of `rob_head_seq` minus 1, or 0 when `rob_empty` is 1. Its `sq_pc` is `commit_pc` and `sq_mispred` is 0. It also resets the youngest sequence number to the boundary value.
- R7: When requests coincide, a firing trap wins over a context trigger, which wins over an execute squash; the losers are dropped. `ctx_req` is ignored while the thread is in TRAPWAIT.
- R8: Any squash puts the thread in SQUASH (code 1) in the next cycle. The first cycle in SQUASH with `rob_done` at 1 and no new squash returns it to RUN. A new squash in that same cycle keeps it in SQUASH.
- R9: `sq_count` equals the number of threads in SQUASH. `ins_block` is 1 exactly when `sq_count` equals the thread count, and while it is 1 `ins_valid` has no effect.
- R10: `ev_squash[t]` and `ev_mispred[t]` are single-cycle pulses one cycle after a cycle with `sq_valid[t]` at 1, and with `sq_valid[t]` and `sq_mispred[t]` both at 1, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | T | Execute squash request per thread |
| ex_seq | input | T*SW | Execute squash sequence number per thread |
| ex_incl | input | T | Include the squashing instruction itself |
| ex_mispred | input | T | Request stems from a mispredicted branch |
| ex_pc | input | T*PW | Redirect PC of the execute request |
| trap_raise | input | T | Trap raised, starts the delay |
| ctx_req | input | T | Context-change squash trigger |
| rob_done | input | T | Reorder buffer finished squashing the thread |
| rob_empty | input | T | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | T*SW | Sequence number at the thread's head |
| ins_valid | input | T | An instruction is inserted this cycle |
| ins_seq | input | T*SW | Sequence number of the inserted instruction |
| commit_pc | input | T*PW | Thread's committed PC |
| sq_valid | output | T | Squash command and broadcast valid |
| sq_bound | output | T*SW | Squash boundary sequence number |
| sq_pc | output | T*PW | Restart PC in the broadcast |
| sq_mispred | output | T | Mispredict flag in the broadcast |
| thr_state | output | 2*T | Per-thread state code |
| sq_count | output | clog2(T+1) | Number of squashing threads |
| ins_block | output | 1 | All threads squashing, insertion held |
| ev_squash | output | T | Pulse per squash, one cycle late |
| ev_mispred | output | T | Pulse per mispredict squash, one cycle late |

## Verification
Several of the thread's functions can land in one cycle. The sharpest case is the delayed trap firing in the same cycle that a context trigger and an execute squash arrive for that thread. The bench lines a context trigger and an execute request flagged as a mispredict up on the exact sixth cycle after a raise. It then judges that the boundary comes from the head sequence number, the PC from the committed PC, and that the mispredict flag is clear.

The second collision is a release flag from the reorder buffer in the same cycle as a new squash. Random traffic with frequent done flags provokes it. A behavioural reference model checked on every clock decides whether the thread must remain squashing.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_SQUASH   = 2'd1,
        ST_TRAPWAIT = 2'd2
    } thr_state_e;

endpackage

// File: rtl/sqc_thread.sv
module sqc_thread
    import sqc_pkg::*;
#(
    parameter int SW  = 16,
    parameter int PW  = 32,
    parameter int DLY = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_valid,
    input  logic [SW-1:0] ex_seq,
    input  logic          ex_incl,
    input  logic          ex_mispred,
    input  logic [PW-1:0] ex_pc,
    input  logic          trap_raise,
    input  logic          ctx_req,
    input  logic          rob_done,
    input  logic          rob_empty,
    input  logic [SW-1:0] head_seq,
    input  logic          ins_valid,
    input  logic [SW-1:0] ins_seq,
    input  logic [PW-1:0] commit_pc,
    output logic          sq_valid,
    output logic [SW-1:0] sq_bound,
    output logic [PW-1:0] sq_pc,
    output logic          sq_mispred,
    output thr_state_e    state,
    output logic          ev_squash,
    output logic          ev_mispred
);

    localparam int          CW   = (DLY > 2) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

    thr_state_e    state_q, state_d;
    logic [SW-1:0] young_q, young_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          evs_q, evm_q;

    logic          fire_trap, fire_ctx, ex_ok, sys_sq;
    logic [SW-1:0] sys_bound, ex_bound;

    // Output decode: squash sources in fixed priority.
    always_comb begin
        fire_trap  = (state_q == ST_TRAPWAIT) && (cnt_q == '0);
        fire_ctx   = !fire_trap && ctx_req && (state_q != ST_TRAPWAIT);
        ex_ok      = !fire_trap && !fire_ctx && ex_valid &&
                     (state_q != ST_TRAPWAIT) && (ex_seq <= young_q);
        sys_sq     = fire_trap || fire_ctx;
        sys_bound  = rob_empty ? '0 : (head_seq - SW'(1));
        ex_bound   = ex_incl ? (ex_seq - SW'(1)) : ex_seq;
        sq_valid   = sys_sq || ex_ok;
        sq_bound   = sys_sq ? sys_bound : ex_bound;
        sq_pc      = sys_sq ? commit_pc : ex_pc;
        sq_mispred = ex_ok && ex_mispred;
        state      = state_q;
        ev_squash  = evs_q;
        ev_mispred = evm_q;
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (sq_valid) begin
                    state_d = ST_SQUASH;
                end else if (trap_raise) begin
                    state_d = ST_TRAPWAIT;
                    cnt_d   = LOAD;
                end
            end
            ST_SQUASH: begin
                if (sq_valid)      state_d = ST_SQUASH;
                else if (rob_done) state_d = ST_RUN;
            end
            ST_TRAPWAIT: begin
                if (sq_valid)          state_d = ST_SQUASH;
                else if (cnt_q != '0)  cnt_d   = cnt_q - CW'(1);
            end
            default: state_d = ST_RUN;
        endcase

        if (sq_valid)       young_d = sq_bound;
        else if (ins_valid) young_d = ins_seq;
        else                young_d = young_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            young_q <= '0;
            cnt_q   <= '0;
            evs_q   <= 1'b0;
            evm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            young_q <= young_d;
            cnt_q   <= cnt_d;
            evs_q   <= sq_valid;
            evm_q   <= sq_mispred;
        end
    end

endmodule

// File: rtl/sqc_tally.sv
module sqc_tally
    import sqc_pkg::*;
#(
    parameter int T    = 2,
    parameter int CNTW = 2
) (
    input  logic [2*T-1:0]  states,
    output logic [CNTW-1:0] count,
    output logic            all_busy
);

    always_comb begin
        count = '0;
        for (int i = 0; i < T; i++) begin
            if (states[2*i +: 2] == ST_SQUASH) count = count + CNTW'(1);
        end
        all_busy = (count == CNTW'(T));
    end

endmodule

// File: rtl/squash_ctl.sv
module squash_ctl
    import sqc_pkg::*;
#(
    parameter int T         = 2,
    parameter int SW        = 16,
    parameter int PW        = 32,
    parameter int TRAP_DELAY = 6,
    localparam int CNTW     = $clog2(T + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [T-1:0]    ex_valid,
    input  logic [T*SW-1:0] ex_seq,
    input  logic [T-1:0]    ex_incl,
    input  logic [T-1:0]    ex_mispred,
    input  logic [T*PW-1:0] ex_pc,
    input  logic [T-1:0]    trap_raise,
    input  logic [T-1:0]    ctx_req,
    input  logic [T-1:0]    rob_done,
    input  logic [T-1:0]    rob_empty,
    input  logic [T*SW-1:0] rob_head_seq,
    input  logic [T-1:0]    ins_valid,
    input  logic [T*SW-1:0] ins_seq,
    input  logic [T*PW-1:0] commit_pc,
    output logic [T-1:0]    sq_valid,
    output logic [T*SW-1:0] sq_bound,
    output logic [T*PW-1:0] sq_pc,
    output logic [T-1:0]    sq_mispred,
    output logic [2*T-1:0]  thr_state,
    output logic [CNTW-1:0] sq_count,
    output logic            ins_block,
    output logic [T-1:0]    ev_squash,
    output logic [T-1:0]    ev_mispred
);

    sqc_tally #(.T(T), .CNTW(CNTW)) u_tally (
        .states   (thr_state),
        .count    (sq_count),
        .all_busy (ins_block)
    );

    for (genvar g = 0; g < T; g++) begin : g_thr
        thr_state_e st_w;

        sqc_thread #(.SW(SW), .PW(PW), .DLY(TRAP_DELAY)) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .ex_valid   (ex_valid[g]),
            .ex_seq     (ex_seq[g*SW +: SW]),
            .ex_incl    (ex_incl[g]),
            .ex_mispred (ex_mispred[g]),
            .ex_pc      (ex_pc[g*PW +: PW]),
            .trap_raise (trap_raise[g]),
            .ctx_req    (ctx_req[g]),
            .rob_done   (rob_done[g]),
            .rob_empty  (rob_empty[g]),
            .head_seq   (rob_head_seq[g*SW +: SW]),
            .ins_valid  (ins_valid[g] && !ins_block),
            .ins_seq    (ins_seq[g*SW +: SW]),
            .commit_pc  (commit_pc[g*PW +: PW]),
            .sq_valid   (sq_valid[g]),
            .sq_bound   (sq_bound[g*SW +: SW]),
            .sq_pc      (sq_pc[g*PW +: PW]),
            .sq_mispred (sq_mispred[g]),
            .state      (st_w),
            .ev_squash  (ev_squash[g]),
            .ev_mispred (ev_mispred[g])
        );

        assign thr_state[2*g +: 2] = st_w;
    end

endmodule

// File: rtl/sqc_checker.sv
module sqc_checker #(
    parameter int T    = 2,
    parameter int CNTW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [T-1:0]    sq_valid,
    input logic [T-1:0]    sq_mispred,
    input logic [T-1:0]    rob_done,
    input logic [2*T-1:0]  thr_state,
    input logic [CNTW-1:0] sq_count,
    input logic            ins_block,
    input logic [T-1:0]    ev_squash,
    input logic [T-1:0]    ev_mispred
);

    for (genvar g = 0; g < T; g++) begin : g_chk
        a_r8_enter_squash: assert property (@(posedge clk) disable iff (!rst_n)
            sq_valid[g] |=> thr_state[2*g +: 2] == 2'd1);

        a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[2*g +: 2] == 2'd1) && rob_done[g] && !sq_valid[g]
            |=> thr_state[2*g +: 2] == 2'd0);

        a_r5_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[2*g +: 2] == 2'd2) && !sq_valid[g]
            |=> thr_state[2*g +: 2] == 2'd2);

        a_r7_trap_no_mispred: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[2*g +: 2] == 2'd2) |-> !sq_mispred[g]);

        a_r10_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            sq_valid[g] |=> ev_squash[g]);

        a_r10_event_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !sq_valid[g] |=> !ev_squash[g] && !ev_mispred[g]);
    end

    a_r9_block_full: assert property (@(posedge clk) disable iff (!rst_n)
        ins_block |-> sq_count == CNTW'(T));

    a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        sq_count <= CNTW'(T));

endmodule

bind squash_ctl sqc_checker #(.T(T), .CNTW(CNTW)) u_sqc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sq_valid   (sq_valid),
    .sq_mispred (sq_mispred),
    .rob_done   (rob_done),
    .thr_state  (thr_state),
    .sq_count   (sq_count),
    .ins_block  (ins_block),
    .ev_squash  (ev_squash),
    .ev_mispred (ev_mispred)
);

// File: tb/squash_ctl_test.sv
module squash_ctl_test;

    localparam int T = 2, SW = 16, PW = 32, DLY = 6, CNTW = 2;
    localparam int CLK_PERIOD = 10;
    localparam int MASK = (1 << SW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [T-1:0]    ex_valid = '0, ex_incl = '0, ex_mispred = '0;
    logic [T*SW-1:0] ex_seq = '0, rob_head_seq = '0, ins_seq = '0;
    logic [T*PW-1:0] ex_pc = '0, commit_pc = '0;
    logic [T-1:0]    trap_raise = '0, ctx_req = '0, rob_done = '0, rob_empty = '0, ins_valid = '0;
    logic [T-1:0]    sq_valid, sq_mispred, ev_squash, ev_mispred;
    logic [T*SW-1:0] sq_bound;
    logic [T*PW-1:0] sq_pc;
    logic [2*T-1:0]  thr_state;
    logic [CNTW-1:0] sq_count;
    logic            ins_block;

    squash_ctl #(.T(T), .SW(SW), .PW(PW), .TRAP_DELAY(DLY)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_st[T], m_young[T], m_cnt[T], m_evs[T], m_evm[T];
    int x_st[T], x_young[T], x_cnt[T], x_evs[T], x_evm[T];
    int e_val[T], e_bnd[T], e_mp[T];
    longint e_pc[T];
    int next_seq[T];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: evaluate outputs, compare, and compute next state.
    task automatic step();
        int busy;
        #(CLK_PERIOD/2 - 2);
        busy = 0;
        for (int t = 0; t < T; t++) if (m_st[t] == 1) busy++;
        for (int t = 0; t < T; t++) begin
            bit ft, fc, eo, sys;
            int hs, es;
            hs = int'(rob_head_seq[t*SW +: SW]);
            es = int'(ex_seq[t*SW +: SW]);
            ft = (m_st[t] == 2) && (m_cnt[t] == 0);
            fc = !ft && ctx_req[t] && (m_st[t] != 2);
            eo = !ft && !fc && ex_valid[t] && (m_st[t] != 2) && (es <= m_young[t]);
            sys = ft || fc;
            e_val[t] = (sys || eo) ? 1 : 0;
            e_bnd[t] = sys ? (rob_empty[t] ? 0 : ((hs - 1) & MASK))
                           : (ex_incl[t] ? ((es - 1) & MASK) : es);
            e_pc[t]  = sys ? longint'(commit_pc[t*PW +: PW]) : longint'(ex_pc[t*PW +: PW]);
            e_mp[t]  = (eo && ex_mispred[t]) ? 1 : 0;

            chk(sq_valid[t] == e_val[t][0], "R2 R4 R7 valid", sq_valid[t], e_val[t]);
            if (e_val[t] != 0) begin
                chk(int'(sq_bound[t*SW +: SW]) == e_bnd[t], "R3 R6 bound",
                    sq_bound[t*SW +: SW], e_bnd[t]);
                chk(longint'(sq_pc[t*PW +: PW]) == e_pc[t], "R6 pc", sq_pc[t*PW +: PW], e_pc[t]);
            end
            chk(sq_mispred[t] == e_mp[t][0], "R3 mispred", sq_mispred[t], e_mp[t]);
            chk(int'(thr_state[2*t +: 2]) == m_st[t], "R8 state", thr_state[2*t +: 2], m_st[t]);
            chk(ev_squash[t] == m_evs[t][0] && ev_mispred[t] == m_evm[t][0], "R10 events",
                {ev_squash[t], ev_mispred[t]}, {m_evs[t][0], m_evm[t][0]});

            x_st[t] = m_st[t]; x_cnt[t] = m_cnt[t];
            if (e_val[t] != 0) x_st[t] = 1;
            else if (m_st[t] == 2) x_cnt[t] = m_cnt[t] - 1;
            else if (m_st[t] == 1 && rob_done[t]) x_st[t] = 0;
            else if (m_st[t] == 0 && trap_raise[t]) begin x_st[t] = 2; x_cnt[t] = DLY - 1; end
            if (e_val[t] != 0) x_young[t] = e_bnd[t];
            else if (ins_valid[t] && busy != T) x_young[t] = int'(ins_seq[t*SW +: SW]);
            else x_young[t] = m_young[t];
            x_evs[t] = e_val[t]; x_evm[t] = e_mp[t];
        end
        chk(int'(sq_count) == busy, "R9 count", sq_count, busy);
        chk(ins_block == (busy == T), "R9 block", ins_block, busy == T);
    endtask

    task automatic advance();
        @(posedge clk);
        if (rst_n) begin
            m_st = x_st; m_young = x_young; m_cnt = x_cnt; m_evs = x_evs; m_evm = x_evm;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        ex_valid = '0; trap_raise = '0; ctx_req = '0; rob_done = '0; ins_valid = '0;
        ex_mispred = '0; ex_incl = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k, fire_k;
        for (int t = 0; t < T; t++) begin
            m_st[t] = 0; m_young[t] = 0; m_cnt[t] = 0; m_evs[t] = 0; m_evm[t] = 0; next_seq[t] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step();
        chk(thr_state == '0, "R1 state", thr_state, 0);
        chk(sq_count == '0 && sq_valid == '0, "R1 idle", sq_count, 0);
        chk(ev_squash == '0, "R1 events", ev_squash, 0);
        advance();

        // R4: insert seq 10 on thread 0
        ins_valid[0] = 1'b1; ins_seq[0 +: SW] = 16'd10;
        step(); advance(); idle();
        // R2: younger request (12) rejected
        ex_valid[0] = 1'b1; ex_seq[0 +: SW] = 16'd12;
        step();
        chk(sq_valid[0] == 1'b0, "R2 younger rejected", sq_valid[0], 0);
        advance();
        // R3: include-self, seq 8 -> boundary 7, mispredict carried
        ex_seq[0 +: SW] = 16'd8; ex_incl[0] = 1'b1; ex_mispred[0] = 1'b1;
        ex_pc[0 +: PW] = 32'h1234;
        step();
        chk(sq_valid[0] && sq_bound[0 +: SW] == 16'd7, "R3 boundary", sq_bound[0 +: SW], 7);
        chk(sq_mispred[0] == 1'b1 && sq_pc[0 +: PW] == 32'h1234, "R3 pc/mispred",
            sq_pc[0 +: PW], 32'h1234);
        advance(); idle();
        // R4: youngest now 7, seq 8 rejected
        ex_valid[0] = 1'b1; ex_seq[0 +: SW] = 16'd8;
        step();
        chk(sq_valid[0] == 1'b0, "R4 youngest lowered", sq_valid[0], 0);
        chk(thr_state[1:0] == 2'd1 && ev_mispred[0], "R8 R10 in squash", thr_state[1:0], 1);
        advance(); idle();
        rob_done[0] = 1'b1; step(); advance(); idle();

        // R5 R6 R7: trap on thread 1, collide with ctx and execute at fire
        rob_empty[1] = 1'b0; rob_head_seq[SW +: SW] = 16'd100; commit_pc[PW +: PW] = 32'hBEEF0;
        trap_raise[1] = 1'b1;
        step(); advance(); idle();
        fire_k = 0;
        for (k = 1; k <= 10 && fire_k == 0; k++) begin
            if (k == DLY) begin
                ctx_req[1] = 1'b1; ex_valid[1] = 1'b1; ex_seq[SW +: SW] = 16'd0;
                ex_mispred[1] = 1'b1; ex_pc[PW +: PW] = 32'h55;
            end
            step();
            if (sq_valid[1]) begin
                fire_k = k;
                chk(sq_bound[SW +: SW] == 16'd99, "R6 head boundary", sq_bound[SW +: SW], 99);
                chk(sq_pc[PW +: PW] == 32'hBEEF0 && !sq_mispred[1], "R7 trap wins",
                    sq_pc[PW +: PW], 32'hBEEF0);
            end
            advance(); idle();
        end
        chk(fire_k == DLY, "R5 trap delay", fire_k, DLY);
        // R5: raise while squashing is ignored
        trap_raise[1] = 1'b1; step(); advance(); idle();
        step();
        chk(thr_state[3:2] == 2'd1, "R5 raise ignored", thr_state[3:2], 1);
        advance();
        rob_done = '1; step(); advance(); idle();

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            for (int t = 0; t < T; t++) begin
                int r;
                r = $urandom_range(0, 99);
                ex_valid[t]   = (r < 30);
                ex_seq[t*SW +: SW] = SW'((m_young[t] + $urandom_range(0, 4) + MASK - 1) & MASK);
                ex_incl[t]    = $urandom_range(0, 1);
                ex_mispred[t] = $urandom_range(0, 1);
                ex_pc[t*PW +: PW] = $urandom;
                trap_raise[t] = ($urandom_range(0, 99) < 4);
                ctx_req[t]    = ($urandom_range(0, 99) < 3);
                rob_done[t]   = ($urandom_range(0, 99) < 30);
                rob_empty[t]  = $urandom_range(0, 1);
                rob_head_seq[t*SW +: SW] = SW'($urandom_range(0, 200));
                commit_pc[t*PW +: PW] = $urandom;
                ins_valid[t]  = ($urandom_range(0, 99) < 50);
                if (ins_valid[t]) next_seq[t] = (next_seq[t] + 1) & MASK;
                ins_seq[t*SW +: SW] = SW'(next_seq[t]);
            end
            step(); advance();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule